// File: doc/BRIEF.md
# Coincidence Multiplicity Trigger Matrix

This block turns a wide set of fast-trigger bits into one trigger bit per group. It looks at three 16-line buses on every core clock: the channels of this module, and the lines that arrive from the neighbouring slot on each side. A configurable number of groups each take their own view of those 48 lines.

Each group runs in one of two modes. In multiplicity mode the group counts how many enabled lines are high on each bus separately. Each bus has its own minimum count, and the group fires only when all three minimums are met. In pick mode the group ignores its masks and counts. It takes one chosen line from each bus and fires when all three chosen lines are high. Every group holds its settings in its own registers, written one group at a time through a simple write strobe. Each group's result leaves the block from a flop.

Top module: `coinc_trig_matrix`

## Requirements
- R1: The input set is three LINES-bit buses (local, left neighbour, right neighbour). Bit i of each bus is line i, and every bus is sampled on each rising clock edge.
- R2: When cfg_we is high at a rising edge, the group addressed by cfg_grp loads cfg_mode, cfg_mask, cfg_thr and cfg_sel, and no other group changes. Inputs sampled at that same edge are still judged with the previous settings. Inputs sampled at the next edge use the new settings.
- R3: In multiplicity mode (cfg_mode = 0), a group fires only when, for each of the three buses, the number of lines that are both high and enabled in the mask is at least that bus's minimum.
- R4: Field positions are as follows. The mask bits [15:0] enable the local lines, [31:16] the left lines and [47:32] the right lines. The minimum for local is cfg_thr[2:0], for left it is [5:3] and for right it is [8:6]. The selector for local is cfg_sel[3:0], for left it is [7:4] and for right it is [11:8].
- R5: A bus whose mask bits are all zero meets its minimum only when that minimum is 0.
- R6: In pick mode (cfg_mode = 1), a group fires exactly when the local, left and right lines named by its three selectors are all high. Its mask and minimums have no effect in this mode.
- R7: grp_trig changes only at a rising edge. It reflects the inputs and settings of the previous edge, which is one cycle of latency.
- R8: While rst is high and after it is released, every grp_trig bit is 0. Reset puts every group in multiplicity mode with zero masks, minimums of 7 and selectors of 0, so no group fires until it is written.
- R9: A minimum of 0 is always met. A minimum of 7 needs at least seven enabled high lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_local | input | LINES | Fast triggers of this module's channels |
| trig_left | input | LINES | Trigger lines from the left neighbour |
| trig_right | input | LINES | Trigger lines from the right neighbour |
| cfg_we | input | 1 | Settings write strobe |
| cfg_grp | input | $clog2(GROUPS) | Group addressed by the write |
| cfg_mode | input | 1 | 0 = multiplicity, 1 = pick |
| cfg_mask | input | 3*LINES | Line enables: local, left, right |
| cfg_thr | input | 3*THR_W | Per-bus minimum counts |
| cfg_sel | input | 3*$clog2(LINES) | Per-bus line selectors for pick mode |
| grp_trig | output | GROUPS | Registered trigger bit of each group |

## Verification
The assertions check four things on every cycle. The outputs are zero right after reset. An output holds while both inputs and settings hold. A pick-mode group stays silent when any bus is all zero. A multiplicity group with a nonzero minimum stays silent when every bus is zero. The exact count comparison, the field positions, the one-edge delay of a settings write and the selector decoding can only be shown by the bench. It sweeps each bus's minimum against every count, walks a single high line past every selector value, and compares random settings and inputs on all groups against its own popcount model.

// File: rtl/coinc_trig_pkg.sv
package coinc_trig_pkg;
  typedef enum logic {
    GRP_MULT = 1'b0,
    GRP_PICK = 1'b1
  } grp_mode_e;

  localparam int unsigned NUM_SRC = 3;  // local, left, right
endpackage

// File: rtl/coinc_line_count.sv
module coinc_line_count #(
  parameter int unsigned LINES = 16,
  parameter int unsigned CNT_W = $clog2(LINES + 1)
) (
  input  logic [LINES-1:0] lines,
  input  logic [LINES-1:0] enable,
  output logic [CNT_W-1:0] count
);
  logic [LINES-1:0] hits;

  assign hits = lines & enable;

  always_comb begin
    count = '0;
    for (int i = 0; i < LINES; i++) begin
      count = count + CNT_W'(hits[i]);
    end
  end
endmodule

// File: rtl/coinc_group_cell.sv
module coinc_group_cell
  import coinc_trig_pkg::*;
#(
  parameter int unsigned LINES = 16,
  parameter int unsigned THR_W = 3,
  localparam int unsigned SEL_W  = $clog2(LINES),
  localparam int unsigned CNT_W  = $clog2(LINES + 1),
  localparam int unsigned MASK_W = NUM_SRC * LINES,
  localparam int unsigned THRS_W = NUM_SRC * THR_W,
  localparam int unsigned SELS_W = NUM_SRC * SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MASK_W-1:0] bus_all,
  input  logic              wr_en,
  input  logic              wr_mode,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [THRS_W-1:0] wr_thr,
  input  logic [SELS_W-1:0] wr_sel,
  output logic              fire_q,
  output logic              mode_q,
  output logic [THRS_W-1:0] thr_q
);
  grp_mode_e         mode_r;
  logic [MASK_W-1:0] mask_r;
  logic [THRS_W-1:0] thr_r;
  logic [SELS_W-1:0] sel_r;
  logic [NUM_SRC-1:0] src_pass;
  logic [NUM_SRC-1:0] src_pick;
  logic               fire_d;

  // settings registers: reset leaves the group unable to fire
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= GRP_MULT;
      mask_r <= '0;
      thr_r  <= '1;
      sel_r  <= '0;
    end else if (wr_en) begin
      mode_r <= grp_mode_e'(wr_mode);
      mask_r <= wr_mask;
      thr_r  <= wr_thr;
      sel_r  <= wr_sel;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [LINES-1:0] line_v;
    logic [CNT_W-1:0] cnt;
    logic [THR_W-1:0] min_v;
    logic [SEL_W-1:0] pick_idx;

    assign line_v   = bus_all[s*LINES +: LINES];
    assign min_v    = thr_r[s*THR_W +: THR_W];
    assign pick_idx = sel_r[s*SEL_W +: SEL_W];

    coinc_line_count #(
      .LINES(LINES),
      .CNT_W(CNT_W)
    ) u_cnt (
      .lines (line_v),
      .enable(mask_r[s*LINES +: LINES]),
      .count (cnt)
    );

    assign src_pass[s] = (cnt >= CNT_W'(min_v));
    assign src_pick[s] = line_v[pick_idx];
  end

  assign fire_d = (mode_r == GRP_PICK) ? (&src_pick) : (&src_pass);

  always_ff @(posedge clk) begin
    if (rst) fire_q <= 1'b0;
    else     fire_q <= fire_d;
  end

  assign mode_q = (mode_r == GRP_PICK);
  assign thr_q  = thr_r;
endmodule

// File: rtl/coinc_trig_matrix.sv
module coinc_trig_matrix
  import coinc_trig_pkg::*;
#(
  parameter int unsigned LINES  = 16,
  parameter int unsigned GROUPS = 16,
  parameter int unsigned THR_W  = 3,
  localparam int unsigned SEL_W  = $clog2(LINES),
  localparam int unsigned GID_W  = $clog2(GROUPS),
  localparam int unsigned MASK_W = NUM_SRC * LINES,
  localparam int unsigned THRS_W = NUM_SRC * THR_W,
  localparam int unsigned SELS_W = NUM_SRC * SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  trig_local,
  input  logic [LINES-1:0]  trig_left,
  input  logic [LINES-1:0]  trig_right,
  input  logic              cfg_we,
  input  logic [GID_W-1:0]  cfg_grp,
  input  logic              cfg_mode,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic [THRS_W-1:0] cfg_thr,
  input  logic [SELS_W-1:0] cfg_sel,
  output logic [GROUPS-1:0] grp_trig
);
  logic [MASK_W-1:0]        bus_all;
  logic [GROUPS-1:0]        grp_mode;
  logic [GROUPS*THRS_W-1:0] grp_thr;

  assign bus_all = {trig_right, trig_left, trig_local};

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic sel_me;
    assign sel_me = cfg_we && (cfg_grp == GID_W'(g));

    coinc_group_cell #(
      .LINES(LINES),
      .THR_W(THR_W)
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .bus_all(bus_all),
      .wr_en  (sel_me),
      .wr_mode(cfg_mode),
      .wr_mask(cfg_mask),
      .wr_thr (cfg_thr),
      .wr_sel (cfg_sel),
      .fire_q (grp_trig[g]),
      .mode_q (grp_mode[g]),
      .thr_q  (grp_thr[g*THRS_W +: THRS_W])
    );
  end
endmodule

// File: rtl/coinc_trig_matrix_chk.sv
module coinc_trig_matrix_chk #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned GROUPS = 16,
  parameter int unsigned THRS_W = 9
) (
  input logic                     clk,
  input logic                     rst,
  input logic [LINES-1:0]         trig_local,
  input logic [LINES-1:0]         trig_left,
  input logic [LINES-1:0]         trig_right,
  input logic                     cfg_we,
  input logic [GROUPS-1:0]        grp_trig,
  input logic [GROUPS-1:0]        grp_mode,
  input logic [GROUPS*THRS_W-1:0] grp_thr
);
  logic any_bus_zero;
  logic all_bus_zero;

  assign any_bus_zero = (trig_local == '0) || (trig_left == '0) || (trig_right == '0);
  assign all_bus_zero = (trig_local == '0) && (trig_left == '0) && (trig_right == '0);

  // R8: outputs are clear on the first cycle after reset
  a_r8_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grp_trig == '0));

  // R7: with inputs and settings unchanged, outputs hold
  a_r7_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_we) && $stable(trig_local) && $stable(trig_left)
     && $stable(trig_right)) |=> $stable(grp_trig));

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    // R6: a pick-mode group cannot fire when any bus is empty
    a_r6_pick_needs_all: assert property (@(posedge clk) disable iff (rst)
      (grp_mode[g] && any_bus_zero) |=> !grp_trig[g]);

    // R3: an all-zero input cannot satisfy a nonzero minimum
    a_r3_empty_blocks: assert property (@(posedge clk) disable iff (rst)
      (!grp_mode[g] && all_bus_zero && (grp_thr[g*THRS_W +: THRS_W] != '0))
      |=> !grp_trig[g]);
  end
endmodule

bind coinc_trig_matrix coinc_trig_matrix_chk #(
  .LINES (LINES),
  .GROUPS(GROUPS),
  .THRS_W(THRS_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trig_local(trig_local),
  .trig_left (trig_left),
  .trig_right(trig_right),
  .cfg_we    (cfg_we),
  .grp_trig  (grp_trig),
  .grp_mode  (grp_mode),
  .grp_thr   (grp_thr)
);

// File: tb/test_coinc_trig_matrix.sv
module test_coinc_trig_matrix;
  localparam int CLK_PERIOD = 10;
  localparam int LINES  = 16;
  localparam int GROUPS = 16;
  localparam int THR_W  = 3;
  localparam int SEL_W  = 4;
  localparam int GID_W  = 4;
  localparam int MASK_W = 3 * LINES;
  localparam int THRS_W = 3 * THR_W;
  localparam int SELS_W = 3 * SEL_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [LINES-1:0]  trig_local = '0;
  logic [LINES-1:0]  trig_left  = '0;
  logic [LINES-1:0]  trig_right = '0;
  logic              cfg_we   = 1'b0;
  logic [GID_W-1:0]  cfg_grp  = '0;
  logic              cfg_mode = 1'b0;
  logic [MASK_W-1:0] cfg_mask = '0;
  logic [THRS_W-1:0] cfg_thr  = '0;
  logic [SELS_W-1:0] cfg_sel  = '0;
  logic [GROUPS-1:0] grp_trig;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench-side copy of every group's settings
  logic              m_mode [GROUPS];
  logic [MASK_W-1:0] m_mask [GROUPS];
  logic [THRS_W-1:0] m_thr  [GROUPS];
  logic [SELS_W-1:0] m_sel  [GROUPS];

  always #(CLK_PERIOD/2) clk = ~clk;

  coinc_trig_matrix #(.LINES(LINES), .GROUPS(GROUPS), .THR_W(THR_W)) i_coinc_trig_matrix (
    .clk(clk), .rst(rst),
    .trig_local(trig_local), .trig_left(trig_left), .trig_right(trig_right),
    .cfg_we(cfg_we), .cfg_grp(cfg_grp), .cfg_mode(cfg_mode),
    .cfg_mask(cfg_mask), .cfg_thr(cfg_thr), .cfg_sel(cfg_sel),
    .grp_trig(grp_trig)
  );

  function automatic int ones(logic [LINES-1:0] v);
    int c = 0;
    for (int i = 0; i < LINES; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [GROUPS-1:0] predict(logic [LINES-1:0] l, logic [LINES-1:0] lf,
                                               logic [LINES-1:0] r);
    logic [GROUPS-1:0] res;
    logic [LINES-1:0]  bus [3];
    bus[0] = l; bus[1] = lf; bus[2] = r;
    for (int g = 0; g < GROUPS; g++) begin
      logic ok = 1'b1;
      for (int s = 0; s < 3; s++) begin
        if (m_mode[g]) begin
          ok &= bus[s][m_sel[g][s*SEL_W +: SEL_W]];
        end else begin
          ok &= (ones(bus[s] & m_mask[g][s*LINES +: LINES]) >= int'(m_thr[g][s*THR_W +: THR_W]));
        end
      end
      res[g] = ok;
    end
    return res;
  endfunction

  task automatic check(string tag, logic [GROUPS-1:0] got, logic [GROUPS-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: grp_trig=%h expected %h", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic write_grp(int g, logic mode, logic [MASK_W-1:0] mask,
                           logic [THRS_W-1:0] thr, logic [SELS_W-1:0] sel);
    cfg_we = 1'b1; cfg_grp = GID_W'(g); cfg_mode = mode;
    cfg_mask = mask; cfg_thr = thr; cfg_sel = sel;
    @(negedge clk);
    cfg_we = 1'b0;
    m_mode[g] = mode; m_mask[g] = mask; m_thr[g] = thr; m_sel[g] = sel;
  endtask

  task automatic apply(string tag, logic [LINES-1:0] l, logic [LINES-1:0] lf, logic [LINES-1:0] r);
    logic [GROUPS-1:0] exp;
    trig_local = l; trig_left = lf; trig_right = r;
    exp = predict(l, lf, r);
    @(negedge clk);
    check(tag, grp_trig, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
    end
  end

  initial begin
    for (int g = 0; g < GROUPS; g++) begin
      m_mode[g] = 1'b0; m_mask[g] = '0; m_thr[g] = '1; m_sel[g] = '0;
    end
    repeat (3) @(negedge clk);
    check("R8 in reset", grp_trig, '0);
    rst = 1'b0;
    check("R8 released", grp_trig, '0);
    // R8: reset settings never fire, even with all lines high
    apply("R8 idle groups", '1, '1, '1);
    apply("R8 idle groups", '0, '0, '0);

    // R5: empty mask passes only with minimum 0
    write_grp(0, 1'b0, '0, '0, '0);
    apply("R5 empty mask N=0", '0, '0, '0);
    write_grp(0, 1'b0, '0, {3'd0, 3'd0, 3'd1}, '0);
    apply("R5 empty mask N=1", '1, '1, '1);

    // R2: write and input at the same edge use the old settings
    write_grp(1, 1'b0, '0, '0, '0);
    cfg_we = 1'b1; cfg_grp = GID_W'(1); cfg_mode = 1'b0;
    cfg_mask = '0; cfg_thr = {3'd0, 3'd0, 3'd2}; cfg_sel = '0;
    trig_local = '1; trig_left = '1; trig_right = '1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R2 old settings at write edge", grp_trig, predict('1, '1, '1));
    m_thr[1] = {3'd0, 3'd0, 3'd2};
    @(negedge clk);
    check("R2 new settings next edge", grp_trig, predict('1, '1, '1));

    // R7: one cycle latency and hold
    apply("R7 latency", 16'h00FF, 16'h0F0F, 16'hFFFF);
    check("R7 hold", grp_trig, predict(16'h00FF, 16'h0F0F, 16'hFFFF));
    @(negedge clk);
    check("R7 hold second cycle", grp_trig, predict(16'h00FF, 16'h0F0F, 16'hFFFF));

    // R4 R9: minimum sweep on each bus at its own field position
    for (int s = 0; s < 3; s++) begin
      for (int nmin = 0; nmin < 8; nmin++) begin
        logic [MASK_W-1:0] mk = '0;
        logic [THRS_W-1:0] th = '0;
        mk[s*LINES +: LINES] = '1;
        th[s*THR_W +: THR_W] = THR_W'(nmin);
        write_grp(2, 1'b0, mk, th, '0);
        for (int k = 0; k <= LINES; k++) begin
          logic [LINES-1:0] v = (k == LINES) ? '1 : LINES'((32'd1 << k) - 1);
          logic [LINES-1:0] b [3];
          b[0] = '0; b[1] = '0; b[2] = '0; b[s] = v;
          apply("R4 R9 minimum sweep", b[0], b[1], b[2]);
        end
      end
    end

    // R6: every selector value against a walking line on each bus
    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < LINES; v++) begin
        logic [SELS_W-1:0] sl = SELS_W'($urandom());
        sl[s*SEL_W +: SEL_W] = SEL_W'(v);
        write_grp(3, 1'b1, MASK_W'({$urandom(), $urandom()}), '0, sl);
        for (int i = 0; i < LINES; i++) begin
          logic [LINES-1:0] b [3];
          b[0] = '1; b[1] = '1; b[2] = '1;
          b[s] = LINES'(1) << i;
          apply("R6 selector walk", b[0], b[1], b[2]);
        end
      end
    end

    // R1 R3 R6: random settings on every group, mixed input density
    for (int round = 0; round < 6; round++) begin
      for (int g = 0; g < GROUPS; g++) begin
        write_grp(g, 1'($urandom()), MASK_W'({$urandom(), $urandom()}),
                  THRS_W'($urandom()), SELS_W'($urandom()));
      end
      for (int n = 0; n < 200; n++) begin
        if (n % 2 == 0)
          apply("R1 R3 R6 random dense", LINES'($urandom() | $urandom()),
                LINES'($urandom() | $urandom()), LINES'($urandom() | $urandom()));
        else
          apply("R1 R3 R6 random", LINES'($urandom()), LINES'($urandom()), LINES'($urandom()));
      end
    end

    // R8: reset in the middle restores idle settings
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int g = 0; g < GROUPS; g++) begin
      m_mode[g] = 1'b0; m_mask[g] = '0; m_thr[g] = '1; m_sel[g] = '0;
    end
    check("R8 mid-run reset", grp_trig, '0);
    apply("R8 settings cleared", '1, '1, '1);

    done = 1;
    finish_run();
  end
endmodule